// File: doc/BRIEF.md
# Multi-Cycle 8-Bit Register Processor Core

This block is a small 8-bit processor with four general registers. One external 8-bit address bus and one 8-bit data bus carry both instructions and data. The data bus is split at the core boundary into an input, an output and an output-enable, so a pad ring can tristate it. Every instruction is one byte. The only exception is load-immediate, which takes its operand from the byte that follows it.

The core runs each instruction as a fixed sequence of steps: fetch, decode, then one of execute, memory read or memory write. A bus interface block sets the timing of the active-low read, write and RAM-select strobes. A store uses an address set-up cycle, a write pulse and a hold cycle. An ALU block computes add, increment, negate and subtract, and it holds the two-bit zero/negative status register. Branches jump to an address held in a register. The branch conditions test the stored status flags.

Top module: `cpu8_core`

## Requirements
- R1: Reset is synchronous and active low (`rst_n`). After a clock edge with `rst_n` low, PC is 0, the status flags are 0 and the core is in fetch. In that state it drives `bus_addr` = 0x00 with `rd_n` low, `wr_n` high and `bus_oe` low.
- R2: Every instruction starts with a fetch of RD_CYCLES cycles. In those cycles `rd_n` is low and `bus_addr` equals PC. The byte on `bus_din` is captured on the last of those edges, and PC is incremented on the same edge. `ram_sel_n` is low during any read or write whose address has bit 7 set, and high otherwise.
- R3: An instruction byte holds the opcode in bits 7..4, Rb in bits 3..2 and Ra in bits 1..0. The opcode values are 0 NOP, 1 LDI, 2 LD, 3 ST, 4 ADD, 5 INC, 6 NEG, 7 SUB, 8 BR, 9 BRZ and A BRN. Rb is both a source and the destination.
- R4: LDI reads the byte at the incremented PC for RD_CYCLES cycles, writes it to Rb and increments PC again. Execution then continues after the data byte.
- R5: LD reads the address in Ra into Rb. ST writes Rb to the address in Ra. A store runs one set-up cycle (address and data driven, `bus_oe` high, `wr_n` high), then WR_PULSE cycles with `wr_n` low, then one hold cycle with address and data still driven.
- R6: ADD gives Rb = Rb + Ra, INC gives Rb = Ra + 1, NEG gives Rb = -Ra and SUB gives Rb = Rb - Ra. All results are modulo 256.
- R7: The status flags are written only by ADD, INC, NEG and SUB. Z is set when the result is 0 and N equals result bit 7. LDI, LD, ST, branches and NOP leave the flags unchanged.
- R8: BR loads PC from Ra. BRZ loads PC from Ra only when the stored Z is 1, and BRN does so only when the stored N is 1. An untaken branch continues at the next byte.
- R9: NOP and the unused opcodes B to F make no bus access beyond their fetch and change no register, flag or memory. Each takes RD_CYCLES+1 cycles.
- R10: `rd_n` and `wr_n` are never low together, and `bus_oe` is never high while `rd_n` is low.
- R11: Decode always takes one cycle. ALU and branch instructions add one execute cycle, so they take RD_CYCLES+2 cycles. LD and LDI take 2*RD_CYCLES+1 cycles, and ST takes RD_CYCLES+WR_PULSE+3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_din | input | 8 | Data bus value returned by memory |
| bus_addr | output | 8 | Memory address |
| bus_dout | output | 8 | Store data driven onto the data bus |
| bus_oe | output | 1 | High while the core drives the data bus |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ram_sel_n | output | 1 | RAM select for addresses 0x80 to 0xFF, active low |

## Verification
The assertions check bus hygiene on every cycle. Read and write never overlap, and the core never drives the bus during a read. Every write pulse has a set-up cycle before it and a hold cycle after it with a steady address. RAM select follows address bit 7 on reads. The status flags hold when no ALU result is written, and the first cycle after reset fetches address 0. The bench compares every strobe, address and store byte on every cycle against an instruction-level model. Only the bench's scenarios can show correct ALU results, taken and untaken branches, flags that survive loads and stores, unused opcodes behaving as NOP, and the final RAM contents.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

    localparam int unsigned WORD_W  = 8;
    localparam int unsigned RIDX_W  = 2;
    localparam int unsigned NUM_GPR = 1 << RIDX_W;
    localparam int unsigned OPC_W   = WORD_W - 2 * RIDX_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [RIDX_W-1:0] ridx_t;
    typedef logic [OPC_W-1:0]  opc_t;

    // Instruction byte layout: opcode high, destination/source next, source low
    typedef struct packed {
        opc_t  opc;
        ridx_t rb;
        ridx_t ra;
    } instr_t;

    localparam opc_t OPC_NOP = 4'h0;
    localparam opc_t OPC_LDI = 4'h1;
    localparam opc_t OPC_LD  = 4'h2;
    localparam opc_t OPC_ST  = 4'h3;
    localparam opc_t OPC_ADD = 4'h4;
    localparam opc_t OPC_INC = 4'h5;
    localparam opc_t OPC_NEG = 4'h6;
    localparam opc_t OPC_SUB = 4'h7;
    localparam opc_t OPC_BR  = 4'h8;
    localparam opc_t OPC_BRZ = 4'h9;
    localparam opc_t OPC_BRN = 4'hA;

    typedef enum logic [2:0] {
        IC_NOP,
        IC_LDI,
        IC_LD,
        IC_ST,
        IC_ALU,
        IC_BRANCH
    } iclass_t;

    typedef enum logic [1:0] {
        FN_ADD,
        FN_INC,
        FN_NEG,
        FN_SUB
    } alu_fn_t;

    typedef struct packed {
        logic z;
        logic n;
    } flags_t;

    typedef enum logic [2:0] {
        S_FETCH,
        S_DECODE,
        S_EXEC,
        S_MEMRD,
        S_MEMWR
    } state_t;

    function automatic iclass_t classify(input opc_t opc);
        case (opc)
            OPC_LDI:                            return IC_LDI;
            OPC_LD:                             return IC_LD;
            OPC_ST:                             return IC_ST;
            OPC_ADD, OPC_INC, OPC_NEG, OPC_SUB: return IC_ALU;
            OPC_BR, OPC_BRZ, OPC_BRN:           return IC_BRANCH;
            default:                            return IC_NOP;
        endcase
    endfunction

    function automatic alu_fn_t alu_fn(input opc_t opc);
        case (opc)
            OPC_INC: return FN_INC;
            OPC_NEG: return FN_NEG;
            OPC_SUB: return FN_SUB;
            default: return FN_ADD;
        endcase
    endfunction

    function automatic logic take_branch(input opc_t opc, input flags_t f);
        case (opc)
            OPC_BR:  return 1'b1;
            OPC_BRZ: return f.z;
            OPC_BRN: return f.n;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cpu8_regfile.sv
module cpu8_regfile
    import cpu8_pkg::*;
#(
    parameter int unsigned N = NUM_GPR
) (
    input  logic  clk,
    input  logic  we,
    input  ridx_t waddr,
    input  word_t wdata,
    input  ridx_t raddr_a,
    input  ridx_t raddr_b,
    output word_t rdata_a,
    output word_t rdata_b
);

    word_t regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        word_t q;
        always_ff @(posedge clk) begin
            if (we && waddr == ridx_t'(g)) begin
                q <= wdata;
            end
        end
        assign regs[g] = q;
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
    import cpu8_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  alu_fn_t fn,
    input  word_t   opa,
    input  word_t   opb,
    input  logic    flags_we,
    output word_t   result,
    output flags_t  flags
);

    always_comb begin
        case (fn)
            FN_ADD:  result = opb + opa;
            FN_INC:  result = opa + word_t'(1);
            FN_NEG:  result = word_t'(0) - opa;
            default: result = opb - opa;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (flags_we) begin
            flags.z <= (result == '0);
            flags.n <= result[WORD_W-1];
        end
    end

endmodule

// File: rtl/cpu8_busif.sv
module cpu8_busif
    import cpu8_pkg::*;
#(
    parameter int unsigned RD_CYCLES = 1,
    parameter int unsigned WR_PULSE  = 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req_rd,
    input  logic  req_wr,
    input  word_t addr,
    input  word_t wdata,
    output logic  done,
    output word_t bus_addr,
    output word_t bus_dout,
    output logic  bus_oe,
    output logic  rd_n,
    output logic  wr_n,
    output logic  ram_sel_n
);

    localparam int unsigned WR_TOTAL = WR_PULSE + 2;
    localparam int unsigned SPAN     = (RD_CYCLES > WR_TOTAL) ? RD_CYCLES : WR_TOTAL;
    localparam int unsigned CNT_W    = $clog2(SPAN + 1);

    logic [CNT_W-1:0] cnt;
    logic             active;
    logic             in_pulse;

    assign active = req_rd || req_wr;

    always_comb begin
        done = 1'b0;
        if (req_rd) begin
            done = (cnt == CNT_W'(RD_CYCLES - 1));
        end else if (req_wr) begin
            done = (cnt == CNT_W'(WR_TOTAL - 1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || done || !active) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // write pulse sits strictly between the set-up cycle and the hold cycle
    assign in_pulse  = req_wr && (cnt >= CNT_W'(1)) && (cnt <= CNT_W'(WR_PULSE));

    assign bus_addr  = addr;
    assign bus_dout  = req_wr ? wdata : '0;
    assign bus_oe    = req_wr;
    assign rd_n      = !req_rd;
    assign wr_n      = !in_pulse;
    assign ram_sel_n = !(active && addr[WORD_W-1]);

endmodule

// File: rtl/cpu8_ctrl.sv
module cpu8_ctrl
    import cpu8_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  instr_t  ir,
    input  flags_t  flags,
    input  logic    bus_done,
    output state_t  state,
    output logic    req_rd,
    output logic    req_wr,
    output logic    addr_from_pc,
    output logic    ir_we,
    output logic    opnd_we,
    output logic    pc_inc,
    output logic    pc_load,
    output logic    rf_we,
    output logic    rf_from_bus,
    output logic    flags_we,
    output alu_fn_t fn
);

    iclass_t cls;
    state_t  nxt;

    assign cls = classify(ir.opc);
    assign fn  = alu_fn(ir.opc);

    always_comb begin
        nxt          = state;
        req_rd       = 1'b0;
        req_wr       = 1'b0;
        addr_from_pc = 1'b0;
        ir_we        = 1'b0;
        opnd_we      = 1'b0;
        pc_inc       = 1'b0;
        pc_load      = 1'b0;
        rf_we        = 1'b0;
        rf_from_bus  = 1'b0;
        flags_we     = 1'b0;
        case (state)
            S_FETCH: begin
                req_rd       = 1'b1;
                addr_from_pc = 1'b1;
                if (bus_done) begin
                    ir_we  = 1'b1;
                    pc_inc = 1'b1;
                    nxt    = S_DECODE;
                end
            end
            S_DECODE: begin
                opnd_we = 1'b1;
                case (cls)
                    IC_NOP:        nxt = S_FETCH;
                    IC_LDI, IC_LD: nxt = S_MEMRD;
                    IC_ST:         nxt = S_MEMWR;
                    default:       nxt = S_EXEC;
                endcase
            end
            S_EXEC: begin
                if (cls == IC_ALU) begin
                    rf_we    = 1'b1;
                    flags_we = 1'b1;
                end else if (cls == IC_BRANCH) begin
                    pc_load = take_branch(ir.opc, flags);
                end
                nxt = S_FETCH;
            end
            S_MEMRD: begin
                req_rd       = 1'b1;
                addr_from_pc = (cls == IC_LDI);
                if (bus_done) begin
                    rf_we       = 1'b1;
                    rf_from_bus = 1'b1;
                    pc_inc      = (cls == IC_LDI);
                    nxt         = S_FETCH;
                end
            end
            S_MEMWR: begin
                req_wr = 1'b1;
                if (bus_done) begin
                    nxt = S_FETCH;
                end
            end
            default: nxt = S_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_FETCH;
        end else begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
    import cpu8_pkg::*;
#(
    parameter int unsigned RD_CYCLES = 1,
    parameter int unsigned WR_PULSE  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_din,
    output logic [7:0] bus_addr,
    output logic [7:0] bus_dout,
    output logic       bus_oe,
    output logic       rd_n,
    output logic       wr_n,
    output logic       ram_sel_n
);

    state_t  state;
    instr_t  ir;
    word_t   pc;
    word_t   opa;
    word_t   opb;
    word_t   rf_a;
    word_t   rf_b;
    word_t   alu_res;
    word_t   rf_wdata;
    word_t   acc_addr;
    flags_t  flags;
    alu_fn_t fn;
    logic    req_rd;
    logic    req_wr;
    logic    addr_from_pc;
    logic    ir_we;
    logic    opnd_we;
    logic    pc_inc;
    logic    pc_load;
    logic    rf_we;
    logic    rf_from_bus;
    logic    flags_we;
    logic    bus_done;

    cpu8_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ir           (ir),
        .flags        (flags),
        .bus_done     (bus_done),
        .state        (state),
        .req_rd       (req_rd),
        .req_wr       (req_wr),
        .addr_from_pc (addr_from_pc),
        .ir_we        (ir_we),
        .opnd_we      (opnd_we),
        .pc_inc       (pc_inc),
        .pc_load      (pc_load),
        .rf_we        (rf_we),
        .rf_from_bus  (rf_from_bus),
        .flags_we     (flags_we),
        .fn           (fn)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
            ir <= '0;
        end else begin
            if (pc_load) begin
                pc <= opa;
            end else if (pc_inc) begin
                pc <= pc + word_t'(1);
            end
            if (ir_we) begin
                ir <= instr_t'(bus_din);
            end
        end
    end

    // operands latched during decode so execute and memory phases see stable values
    always_ff @(posedge clk) begin
        if (opnd_we) begin
            opa <= rf_a;
            opb <= rf_b;
        end
    end

    assign rf_wdata = rf_from_bus ? bus_din : alu_res;
    assign acc_addr = addr_from_pc ? pc : opa;

    cpu8_regfile #(.N(NUM_GPR)) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (ir.rb),
        .wdata   (rf_wdata),
        .raddr_a (ir.ra),
        .raddr_b (ir.rb),
        .rdata_a (rf_a),
        .rdata_b (rf_b)
    );

    cpu8_alu u_alu (
        .clk      (clk),
        .rst_n    (rst_n),
        .fn       (fn),
        .opa      (opa),
        .opb      (opb),
        .flags_we (flags_we),
        .result   (alu_res),
        .flags    (flags)
    );

    cpu8_busif #(
        .RD_CYCLES (RD_CYCLES),
        .WR_PULSE  (WR_PULSE)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_rd    (req_rd),
        .req_wr    (req_wr),
        .addr      (acc_addr),
        .wdata     (opb),
        .done      (bus_done),
        .bus_addr  (bus_addr),
        .bus_dout  (bus_dout),
        .bus_oe    (bus_oe),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .ram_sel_n (ram_sel_n)
    );

endmodule

// File: rtl/cpu8_core_chk.sv
module cpu8_core_chk
    import cpu8_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic       bus_oe,
    input logic [7:0] bus_addr,
    input logic       ram_sel_n,
    input flags_t     flags,
    input logic       flags_we
);

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R10
    drive_vs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> rd_n);

    // R5
    wr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> ($past(bus_oe) && $stable(bus_addr)));

    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (bus_oe && $stable(bus_addr)));

    // R2
    ram_sel_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && bus_addr[7]) |-> !ram_sel_n);

    // R7
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_we |=> $stable(flags));

    // R1
    reset_fetch_chk: assert property (@(posedge clk)
        !rst_n |=> (bus_addr == 8'h00 && !rd_n && wr_n && !bus_oe));

endmodule

bind cpu8_core cpu8_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .bus_oe    (bus_oe),
    .bus_addr  (bus_addr),
    .ram_sel_n (ram_sel_n),
    .flags     (flags),
    .flags_we  (flags_we)
);

// File: tb/tb_cpu8_core.sv
module tb_cpu8_core;

    localparam int RD_CYC = 1;
    localparam int WR_PUL = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_din;
    logic [7:0] bus_addr;
    logic [7:0] bus_dout;
    logic       bus_oe;
    logic       rd_n;
    logic       wr_n;
    logic       ram_sel_n;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;

    logic [7:0] mem       [256];
    logic [7:0] model_mem [256];
    logic [7:0] m_regs    [4];
    logic [7:0] m_pc;
    logic       m_z;
    logic       m_n;

    always #10 clk = ~clk;

    cpu8_core #(.RD_CYCLES(RD_CYC), .WR_PULSE(WR_PUL)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_din   (bus_din),
        .bus_addr  (bus_addr),
        .bus_dout  (bus_dout),
        .bus_oe    (bus_oe),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .ram_sel_n (ram_sel_n)
    );

    // memory attached to the bus: low half read-only, high half writable
    always_comb bus_din = !rd_n ? mem[bus_addr] : 8'h00;

    always @(posedge clk) begin
        if (!wr_n && !ram_sel_n && bus_oe) mem[bus_addr] <= bus_dout;
    end

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            miscompares++;
            $display("FAIL R11 watchdog: got %0d cycles, expected under 20000", cyc);
            finish_run();
        end
    end

    task automatic put(input int a, input logic [7:0] v);
        mem[a]       = v;
        model_mem[a] = v;
    endtask

    task automatic load_prog();
        for (int i = 0; i < 256; i++) put(i, 8'h00);
        put('h00, 8'h10); put('h01, 8'h05);   // LDI r0 = 05
        put('h02, 8'h14); put('h03, 8'h80);   // LDI r1 = 80
        put('h04, 8'h31);                     // ST  r0 -> [r1]
        put('h05, 8'h29);                     // LD  r2 <- [r1]
        put('h06, 8'h48);                     // ADD r2 += r0
        put('h07, 8'h5D);                     // INC r3 = r1+1
        put('h08, 8'h3B);                     // ST  r2 -> [r3]
        put('h09, 8'h60);                     // NEG r0 = -r0
        put('h0A, 8'h78);                     // SUB r2 -= r0
        put('h0B, 8'h14); put('h0C, 8'h30);   // LDI r1 = 30
        put('h0D, 8'hA1);                     // BRN r1 (not taken)
        put('h0E, 8'h91);                     // BRZ r1 (not taken)
        put('h0F, 8'hF3);                     // unused opcode
        put('h10, 8'h00);                     // NOP
        put('h11, 8'h70);                     // SUB r0 -= r0 -> Z
        put('h12, 8'h1C); put('h13, 8'h82);   // LDI r3 = 82
        put('h14, 8'h3B);                     // ST  r2 -> [r3]
        put('h15, 8'h91);                     // BRZ r1 (taken)
        put('h16, 8'h18); put('h17, 8'hEE);   // skipped
        put('h18, 8'h3B);                     // skipped
        put('h30, 8'h10); put('h31, 8'hFF);   // LDI r0 = FF
        put('h32, 8'h38);                     // ST  r2 -> [r0]
        put('h33, 8'h14); put('h34, 8'h01);   // LDI r1 = 01
        put('h35, 8'h65);                     // NEG r1 -> N
        put('h36, 8'h1C); put('h37, 8'h3A);   // LDI r3 = 3A
        put('h38, 8'hA3);                     // BRN r3 (taken)
        put('h39, 8'h7F);                     // skipped
        put('h3A, 8'h1C); put('h3B, 8'h3C);   // LDI r3 = 3C
        put('h3C, 8'h83);                     // BR r3 (self loop)
    endtask

    // compare one cycle of bus activity, then advance to the next falling edge
    task automatic step(input logic e_rd_n, input logic e_wr_n, input logic e_oe,
                        input logic [7:0] e_addr, input logic [7:0] e_dout,
                        input string tag);
        logic access;
        logic e_sel_n;
        logic bad;
        access  = !e_rd_n || e_oe;
        e_sel_n = !(access && e_addr[7]);
        bad = (rd_n !== e_rd_n) || (wr_n !== e_wr_n) || (bus_oe !== e_oe) ||
              (ram_sel_n !== e_sel_n) || (access && bus_addr !== e_addr) ||
              (e_oe && bus_dout !== e_dout);
        vectors++;
        if (bad) begin
            miscompares++;
            $display("FAIL %s: got rd_n=%b wr_n=%b oe=%b sel_n=%b addr=%h dout=%h, expected rd_n=%b wr_n=%b oe=%b sel_n=%b addr=%h dout=%h",
                     tag, rd_n, wr_n, bus_oe, ram_sel_n, bus_addr, bus_dout,
                     e_rd_n, e_wr_n, e_oe, e_sel_n, e_addr, e_dout);
        end
        @(negedge clk);
    endtask

    task automatic check_mem(input int a, input logic [7:0] e, input string tag);
        vectors++;
        if (mem[a] !== e) begin
            miscompares++;
            $display("FAIL %s: mem[%h] got %h, expected %h", tag, a[7:0], mem[a], e);
        end
    endtask

    // instruction-level model emitting the expected bus cycles of one instruction
    task automatic run_one();
        logic [7:0] iw;
        logic [3:0] op;
        logic [1:0] rb;
        logic [1:0] ra;
        logic [7:0] res;
        logic       taken;
        iw = model_mem[m_pc];
        for (int i = 0; i < RD_CYC; i++) step(1'b0, 1'b1, 1'b0, m_pc, 8'h00, "R2 fetch");
        m_pc = m_pc + 8'd1;
        op = iw[7:4];
        rb = iw[3:2];
        ra = iw[1:0];
        step(1'b1, 1'b1, 1'b0, 8'h00, 8'h00, "R11 decode");
        case (op)
            4'h1: begin
                for (int i = 0; i < RD_CYC; i++) step(1'b0, 1'b1, 1'b0, m_pc, 8'h00, "R4 LDI operand");
                m_regs[rb] = model_mem[m_pc];
                m_pc = m_pc + 8'd1;
            end
            4'h2: begin
                for (int i = 0; i < RD_CYC; i++) step(1'b0, 1'b1, 1'b0, m_regs[ra], 8'h00, "R5 LD read");
                m_regs[rb] = model_mem[m_regs[ra]];
            end
            4'h3: begin
                step(1'b1, 1'b1, 1'b1, m_regs[ra], m_regs[rb], "R5 ST setup");
                for (int i = 0; i < WR_PUL; i++) step(1'b1, 1'b0, 1'b1, m_regs[ra], m_regs[rb], "R5 ST pulse");
                step(1'b1, 1'b1, 1'b1, m_regs[ra], m_regs[rb], "R5 ST hold");
                if (m_regs[ra][7]) model_mem[m_regs[ra]] = m_regs[rb];
            end
            4'h4, 4'h5, 4'h6, 4'h7: begin
                step(1'b1, 1'b1, 1'b0, 8'h00, 8'h00, "R6 R3 ALU execute");
                case (op)
                    4'h4:    res = m_regs[rb] + m_regs[ra];
                    4'h5:    res = m_regs[ra] + 8'd1;
                    4'h6:    res = 8'd0 - m_regs[ra];
                    default: res = m_regs[rb] - m_regs[ra];
                endcase
                m_regs[rb] = res;
                m_z = (res == 8'h00);
                m_n = res[7];
            end
            4'h8, 4'h9, 4'hA: begin
                step(1'b1, 1'b1, 1'b0, 8'h00, 8'h00, "R8 branch execute");
                taken = (op == 4'h8) || (op == 4'h9 && m_z) || (op == 4'hA && m_n);
                if (taken) m_pc = m_regs[ra];
            end
            default: ;  // R9: NOP and unused opcodes end after decode
        endcase
    endtask

    initial begin
        load_prog();
        m_pc = 8'h00;
        m_z  = 1'b0;
        m_n  = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state, observed while reset is still applied
        step(1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R1 reset state");
        rst_n = 1'b1;
        for (int k = 0; k < 40; k++) run_one();
        // R5 R6 R7 R8 R9: RAM results computed by hand from the program
        check_mem('h80, 8'h05, "R5 store of loaded value");
        check_mem('h81, 8'h0A, "R6 ADD result via INC address");
        check_mem('h82, 8'h0F, "R6 SUB/NEG result, R8 R7 BRZ taken after LDI/ST");
        check_mem('hFF, 8'h0F, "R5 store to top RAM address");
        check_mem('h83, 8'h00, "R9 no stray write");
        // R1: reset applied mid-run returns to fetch at address 0
        rst_n = 1'b0;
        @(negedge clk);
        step(1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R1 reset mid-run");
        finish_run();
    end

endmodule